// File: doc/BRIEF.md
# RC Oscillator 32 kHz Divider with Calibrated Path

This block derives a nominal 32 kHz clock from a free-running 16 MHz internal RC oscillator, whose frequency may be off by as much as about 30%. All of its logic runs on the RC clock. A fixed divide-by-32 prescaler feeds a programmable second stage that divides by N+1. N is a 5-bit field that software writes.

For parts whose RC frequency has been measured, a calibration register carries a fixed-point divider value. When both its enable and select bits are set, the output comes from a phase accumulator instead of the integer chain. Each RC cycle the accumulator advances by two units, and it wraps at the programmed divider value. The average output period therefore equals the fixed-point value in RC cycles, which lets software land on 32768 Hz despite the oscillator's spread.

A small word-wide register port with write strobe, address and combinational read data gives access to both registers. The measurement logic that computes calibration values lies outside this block.

Top module: `rcdiv32k_top`

## Requirements
- R1: While reset is low, `clk32_o` is 0. After reset, the divider register (offset 0x8) and the calibration register (offset 0xC) both read 0, and the integer divider path drives the output.
- R2: In integer mode the output period is 32*(N+1) RC cycles, where N is bits 4:0 of the divider register. N=0 gives 32 and N=31 gives 1024.
- R3: In integer mode the output is high for exactly half of each period, starting at the rising edge.
- R4: A new N takes effect only at the next period boundary. The period in progress completes with the old length, and the following period has the new length.
- R5: In the calibration register, bit 1 is enable and bit 0 is select. Bits 31:2 hold the divider value D in fixed point, with its ones place at bit 22 (20 fraction bits). With both bits set, k consecutive output periods last k*D RC cycles to within one cycle, and exactly when D is an integer.
- R6: Setting select alone or enable alone leaves the integer divider driving the output. Clearing either bit returns the output to the integer divider.
- R7: The divider register reads N in bits 4:0 and zeros above. The calibration register reads back exactly what was written. Any other address reads 0, and writes to it change no register and no output period.
- R8: Within one selected source, no complete high or low phase of the output lasts more than 512 RC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC oscillator clock, nominal 16 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| clk32_o | output | 1 | Divided 32 kHz output clock, registered |

## Verification
A wrong prescaler or second-stage count shows as an output period that is off by a multiple of 32 cycles from the first full period after the divisor settles. An early divisor load shows as a truncated period straight after a mid-period write. A faulty accumulator shows as multi-period lengths that drift more than one cycle from k*D within a few periods. A wrong source decode shows as a period of the wrong kind one period after the calibration register is written.

// File: rtl/rcdiv_pkg.sv
// Shared constants for the RC 32 kHz divider: register offsets and
// the bit layout of the calibration register.
package rcdiv_pkg;
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 4;
    localparam logic [ADDR_W-1:0] DIV_OFS = 4'h8;
    localparam logic [ADDR_W-1:0] CAL_OFS = 4'hC;
    localparam int CAL_SEL_BIT   = 0;
    localparam int CAL_EN_BIT    = 1;
    localparam int CAL_FIELD_LSB = 2;
endpackage

// File: rtl/rcdiv_regs.sv
// Register file for the divider: the N field and the calibration word.
// Assumes single-cycle writes; reads are combinational on the address.
module rcdiv_regs
    import rcdiv_pkg::*;
#(
    parameter int N_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_W-1:0]    div_field,
    output logic [DATA_W-1:0] cal_word
);
    // Register update on decoded writes; unmapped offsets are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_field <= '0;
            cal_word  <= '0;
        end else if (we) begin
            case (addr)
                DIV_OFS: div_field <= wdata[N_W-1:0];
                CAL_OFS: cal_word  <= wdata;
                default: ;
            endcase
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (addr)
            DIV_OFS: rdata = DATA_W'(div_field);
            CAL_OFS: rdata = cal_word;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/rcdiv_intdiv.sv
// Integer chain: a fixed 2**PRE_W prescaler cascaded with an (N+1)
// stage. The active N is reloaded only when the period wraps, so a
// write never shortens the period in progress. The output is high for
// the first half of each period.
module rcdiv_intdiv #(
    parameter int PRE_W = 5,
    parameter int N_W   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] div_field,
    output logic [N_W-1:0] act_o,
    output logic           at_start_o,
    output logic           div_q
);
    localparam int POS_W = PRE_W + N_W;

    logic [PRE_W-1:0] pre;
    logic [N_W-1:0]   stg;
    logic [N_W-1:0]   act;
    logic [POS_W:0]   thr;
    logic [POS_W:0]   pos_ext;

    // Prescaler and second stage advance; divisor reloads at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
            stg <= '0;
            act <= '0;
        end else begin
            pre <= pre + 1'b1;
            if (pre == {PRE_W{1'b1}}) begin
                if (stg == act) begin
                    stg <= '0;
                    act <= div_field;
                end else begin
                    stg <= stg + 1'b1;
                end
            end
        end
    end

    // Half-period threshold and level of the integer output.
    always_comb begin
        thr     = ((POS_W+1)'(act) + (POS_W+1)'(1)) << (PRE_W - 1);
        pos_ext = {1'b0, stg, pre};
        div_q   = (pos_ext < thr);
    end

    assign act_o      = act;
    assign at_start_o = (pre == '0) && (stg == '0);
endmodule

// File: rtl/rcdiv_calacc.sv
// Fractional path: a phase accumulator that gains two fixed-point
// units per clock and wraps at the programmed divider value D; each
// wrap toggles the output, so the average period is D clocks.
// Held cleared while disabled.
module rcdiv_calacc #(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [INT_W+FRAC_W-1:0] div_val,
    output logic                    tgl_q
);
    localparam int ACC_W = INT_W + FRAC_W + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(2) << FRAC_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] nxt;
    logic [ACC_W-1:0] lim;
    logic             wrap;

    // Next phase and wrap detection.
    always_comb begin
        nxt  = acc + STEP;
        lim  = {1'b0, div_val};
        wrap = (nxt >= lim);
    end

    // Phase update and output toggle on every wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            acc   <= '0;
            tgl_q <= 1'b0;
        end else if (wrap) begin
            acc   <= nxt - lim;
            tgl_q <= ~tgl_q;
        end else begin
            acc   <= nxt;
        end
    end
endmodule

// File: rtl/rcdiv32k_top.sv
// Top of the RC 32 kHz divider: registers, integer chain, calibrated
// accumulator and the registered source select. Everything runs on
// the RC clock; the output is a registered level.
module rcdiv32k_top
    import rcdiv_pkg::*;
#(
    parameter int PRE_W  = 5,
    parameter int N_W    = 5,
    parameter int INT_W  = 10,
    parameter int FRAC_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk32_o
);
    localparam int CAL_W = INT_W + FRAC_W;

    logic [N_W-1:0]    div_field;
    logic [DATA_W-1:0] cal_word;
    logic [N_W-1:0]    act_div;
    logic              at_start;
    logic              div_q;
    logic              cal_tgl;
    logic              cal_en;
    logic              cal_sel;
    logic              use_cal;

    rcdiv_regs #(.N_W(N_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .div_field (div_field),
        .cal_word  (cal_word)
    );

    rcdiv_intdiv #(.PRE_W(PRE_W), .N_W(N_W)) u_intdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_field  (div_field),
        .act_o      (act_div),
        .at_start_o (at_start),
        .div_q      (div_q)
    );

    assign cal_en  = cal_word[CAL_EN_BIT];
    assign cal_sel = cal_word[CAL_SEL_BIT];
    assign use_cal = cal_en && cal_sel;

    rcdiv_calacc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_calacc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cal_en),
        .div_val (cal_word[CAL_FIELD_LSB +: CAL_W]),
        .tgl_q   (cal_tgl)
    );

    // Registered source select drives the output.
    always_ff @(posedge clk) begin
        if (!rst_n) clk32_o <= 1'b0;
        else        clk32_o <= use_cal ? cal_tgl : div_q;
    end
endmodule

// File: rtl/rcdiv32k_chk.sv
// Assertion checker for rcdiv32k_top, attached by bind below.
module rcdiv32k_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [3:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        clk32_o,
    input logic [4:0]  act_div,
    input logic        at_start,
    input logic        cal_en,
    input logic        use_cal,
    input logic        cal_tgl
);
    logic [10:0] run;
    logic        prev_o;
    logic        prev_sel;

    // Length of the current output phase, restarted on a source change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= '0;
            prev_o   <= 1'b0;
            prev_sel <= 1'b0;
        end else begin
            prev_o   <= clk32_o;
            prev_sel <= use_cal;
            if (clk32_o != prev_o || use_cal != prev_sel) run <= '0;
            else if (run != '1)                          run <= run + 1'b1;
        end
    end

    p_phase_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run < 11'd512);

    p_load_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_div) |-> at_start);

    p_div_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 4'h8) |=>
        (reg_we || reg_addr != 4'h8 || reg_rdata[4:0] == $past(reg_wdata[4:0])));

    p_cal_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_en |=> !cal_tgl);

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != 4'h8 && reg_addr != 4'hC) |-> reg_rdata == 32'd0);
endmodule

bind rcdiv32k_top rcdiv32k_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .clk32_o   (clk32_o),
    .act_div   (act_div),
    .at_start  (at_start),
    .cal_en    (cal_en),
    .use_cal   (use_cal),
    .cal_tgl   (cal_tgl)
);

// File: tb/rcdiv32k_top_bench.sv
// Bench for rcdiv32k_top: directed corners plus seeded random divisors
// and calibration values, with periods measured at the output pin.
module rcdiv32k_top_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk32_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int run_len = 0;
    int max_run = 0;
    int skip_ph = 0;
    logic last_o = 1'b0;

    rcdiv32k_top u_rcdiv32k_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .clk32_o   (clk32_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Length of each complete output phase, for R8.
    always @(negedge clk) begin
        if (rst_n) begin
            if (clk32_o != last_o) begin
                if (skip_ph > 0) skip_ph <= skip_ph - 1;
                else if (run_len > max_run) max_run <= run_len;
                run_len <= 1;
            end else begin
                run_len <= run_len + 1;
            end
        end
        last_o <= clk32_o;
    end

    function automatic int exp_div_period(int n);
        return 32 * (n + 1);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 4'hC) skip_ph = 2;
    endtask

    task automatic read_reg(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_edge(bit rise, output int at);
        logic was;
        was = clk32_o;
        forever begin
            @(negedge clk);
            if (clk32_o == rise && was == !rise) begin
                at = cyc;
                return;
            end
            was = clk32_o;
        end
    endtask

    // Integer mode: program N, settle, then check period (R2) and high time (R3).
    task automatic measure_div(int n);
        int t0, f, t1;
        write_reg(4'h8, 32'(n));
        wait_edge(1'b1, t0);
        wait_edge(1'b1, t0);
        wait_edge(1'b0, f);
        wait_edge(1'b1, t1);
        check(t1 - t0 == exp_div_period(n), "R2 period", t1 - t0, exp_div_period(n));
        check(f - t0 == exp_div_period(n) / 2, "R3 high time", f - t0, exp_div_period(n) / 2);
    endtask

    // Calibrated mode: D in units of 2**-20; four periods within one cycle of 4*D (R5).
    task automatic measure_cal(longint dfix);
        int t0, t1;
        longint diff;
        write_reg(4'hC, (32'(dfix) << 2) | 32'h3);
        wait_edge(1'b1, t0);
        wait_edge(1'b1, t0);
        repeat (4) wait_edge(1'b1, t1);
        diff = (longint'(t1 - t0) << 20) - 4 * dfix;
        if (diff < 0) diff = -diff;
        check(diff <= (longint'(1) << 20), "R5 calibrated 4-period length",
              longint'(t1 - t0), (4 * dfix) >> 20);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int t0, t1, t2;
        longint dfix;
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (4) @(negedge clk);
        check(clk32_o == 1'b0, "R1 output low in reset", clk32_o, 0);
        rst_n = 1'b1;
        read_reg(4'h8, rd);
        check(rd == 0, "R1 divider reg after reset", rd, 0);
        read_reg(4'hC, rd);
        check(rd == 0, "R1 calibration reg after reset", rd, 0);
        wait_edge(1'b1, t0);
        wait_edge(1'b1, t1);
        check(t1 - t0 == 32, "R1 integer path after reset", t1 - t0, 32);

        // R2/R3: corners and random N
        measure_div(0);
        measure_div(31);
        measure_div(5);
        for (int i = 0; i < 6; i++) measure_div(int'($urandom % 32));

        // R4: mid-period change completes the old period first
        measure_div(3);
        wait_edge(1'b1, t0);
        repeat (10) @(negedge clk);
        write_reg(4'h8, 32'd20);
        wait_edge(1'b1, t1);
        wait_edge(1'b1, t2);
        check(t1 - t0 == 128, "R4 old period kept", t1 - t0, 128);
        check(t2 - t1 == exp_div_period(20), "R4 new period", t2 - t1, exp_div_period(20));

        // R7: readback and unmapped writes
        write_reg(4'h8, 32'hFFFF_FFE7);
        read_reg(4'h8, rd);
        check(rd == 32'h7, "R7 divider readback masks upper bits", rd, 7);
        write_reg(4'h4, 32'hFFFF_FFFF);
        read_reg(4'h4, rd);
        check(rd == 0, "R7 unmapped reads zero", rd, 0);
        read_reg(4'h8, rd);
        check(rd == 32'h7, "R7 unmapped write leaves divider", rd, 7);
        read_reg(4'hC, rd);
        check(rd == 0, "R7 unmapped write leaves calibration", rd, 0);
        wait_edge(1'b1, t0);
        wait_edge(1'b1, t1);
        check(t1 - t0 == 256, "R7 period unchanged by unmapped write", t1 - t0, 256);

        // R5: calibrated path, integer and fractional D
        measure_cal(longint'(20) << 20);
        measure_cal((longint'(300) << 20) | (longint'(1) << 18));
        for (int i = 0; i < 3; i++) begin
            dfix = (longint'(100 + $urandom % 400) << 20) | longint'($urandom & 32'hFFFFF);
            measure_cal(dfix);
            read_reg(4'hC, rd);
            check(rd == ((32'(dfix) << 2) | 32'h3), "R7 calibration readback", rd,
                  (dfix << 2) | 3);
        end

        // R6: select-only and enable-only leave the integer path
        write_reg(4'hC, 32'h0);
        measure_div(1);
        write_reg(4'hC, (32'd20 << 22) | 32'h1);
        wait_edge(1'b1, t0); wait_edge(1'b1, t0); wait_edge(1'b1, t1);
        check(t1 - t0 == 64, "R6 select alone", t1 - t0, 64);
        write_reg(4'hC, (32'd20 << 22) | 32'h2);
        wait_edge(1'b1, t0); wait_edge(1'b1, t0); wait_edge(1'b1, t1);
        check(t1 - t0 == 64, "R6 enable alone", t1 - t0, 64);
        write_reg(4'hC, (32'd20 << 22) | 32'h3);
        wait_edge(1'b1, t0); wait_edge(1'b1, t0); wait_edge(1'b1, t1);
        check(t1 - t0 == 20, "R5 both bits select calibrated", t1 - t0, 20);
        write_reg(4'hC, 32'h0);
        wait_edge(1'b1, t0); wait_edge(1'b1, t0); wait_edge(1'b1, t1);
        check(t1 - t0 == 64, "R6 cleared returns to integer", t1 - t0, 64);

        // R8: longest complete phase seen
        check(max_run <= 512, "R8 longest phase", max_run, 512);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule